// File: doc/BRIEF.md
# Frame Status FIFO Controller

This block sits behind a bit-oriented serial deframer. Received bytes go into a small data FIFO. For each finished frame, a separate status queue keeps the frame's byte count and its error/end bits. A host reads the received bytes, the byte count and the status through one register-read port. An interrupt line tells the host when to read, according to one of four receive interrupt modes.

Special receive conditions are a CRC error or an end-of-frame marker on a byte at the FIFO exit. In the modes that lock, such a condition freezes the FIFO exit once the host has read the status register and then taken out the offending byte. The exit stays frozen until an error-reset command. The status queue changes this in one case: when the queue is on and the mode is special-only, a clean end of frame is not a special condition. It raises a latched data-available interrupt and does not lock, so the next frame's bytes stay readable. The host only has to issue a reset-in-service command afterwards.

Top module: `frame_status_ctrl`

## Requirements
- R1: The data FIFO returns bytes in arrival order and holds 8 bytes. A byte that arrives while it is full is dropped and sets the sticky overrun bit, status bit 5.
- R2: The byte count counts every received byte of a frame, including the end byte, and restarts at zero after each end of frame. Count-low (select 1) and count-high (select 2) show the queue head's count when the queue is on and holds an entry, and the live count otherwise.
- R3: The status queue holds 10 frames. An end of frame that arrives while the queue is full is discarded and sets the sticky queue-overflow bit, status bit 4.
- R4: A status read (select 3) shows end-of-frame in bit 7 and CRC error in bit 6. These come from the queue head when the queue is on and holds an entry, and in that case the read pops the entry. Entries come out in frame order.
- R5: With the queue on and mode 3 (special only), a clean end-of-frame byte at the FIFO exit latches an interrupt. It does not lock the FIFO, and later bytes stay readable.
- R6: In mode 1 or mode 3, a status read while a special byte is at the exit locks the FIFO. The next data read (select 0) removes the special byte. Further data reads return the new head without removing it, until an error reset.
- R7: In mode 2 (every character), special conditions never lock the FIFO, and the interrupt is high whenever the FIFO holds a byte.
- R8: The latched end-of-frame interrupt stays set until a reset-in-service command.
- R9: An error reset clears the lock and both sticky bits.
- R10: With the queue off, an end-of-frame byte at the exit is a special condition. It raises the interrupt and can lock the FIFO.
- R11: In mode 1, the first byte received after reset or an error reset raises an interrupt that holds until a reset-in-service command. Later bytes do not raise it again.
- R12: Mode 0 keeps the interrupt low for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte from deframer valid this cycle |
| inByte | input | 8 | Received byte |
| inEof | input | 1 | Byte is the last of its frame |
| inCrcErr | input | 1 | Frame failed its CRC (with the end byte) |
| cfgQueueEn | input | 1 | Status queue enable |
| cfgIrqMode | input | 2 | 0 off, 1 first char or special, 2 every char or special, 3 special only |
| cmdErrReset | input | 1 | Error-reset command pulse |
| cmdResetIus | input | 1 | Reset-in-service command pulse |
| rdStrobe | input | 1 | Host register read this cycle |
| rdSel | input | 2 | 0 data, 1 count low, 2 count high, 3 status |
| rdValue | output | 8 | Value of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes 11 frames against a 10-entry queue. A design with an off-by-one depth or a pointer that wraps wrongly would give the wrong count or status sequence, or no overflow bit. It locks the FIFO and then reads twice. A design that keeps popping while locked would return the next byte instead of repeating the head. It checks that a clean end of frame in special-only mode with the queue on leaves the next frame readable, and that it holds the interrupt until reset-in-service. A design that locked here, or that cleared the interrupt when the byte was read, would fail those checks. It also checks that the first-character interrupt fires only once per arming.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF     = 2'd0,
    IRQ_FIRST   = 2'd1,
    IRQ_ALL     = 2'd2,
    IRQ_SPECIAL = 2'd3
  } irqMode_t;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_CNT_HI = 2'd2,
    SEL_STATUS = 2'd3
  } rdSel_t;

  typedef enum logic [1:0] {
    LK_OPEN   = 2'd0,
    LK_HELD   = 2'd1,
    LK_FROZEN = 2'd2
  } lockState_t;

  typedef struct packed {
    logic dataPush;
    logic dataPop;
    logic qPush;
    logic qPop;
    logic qOvfSet;
    logic clrSticky;
  } strobes_t;
endpackage

// File: rtl/fsq_ring.sv
module fsq_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));

  AST_RING_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full); // R1
  AST_RING_POP_DATA: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R4
endmodule

// File: rtl/fsq_datapath.sv
module fsq_datapath
  import fsq_pkg::*;
#(
  parameter int DATA_DEPTH  = 8,
  parameter int QUEUE_DEPTH = 10,
  parameter int CNT_W       = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   strobes,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       inEof,
  input  logic       inCrcErr,
  input  logic       cfgQueueEn,
  input  logic [1:0] rdSel,
  output logic [7:0] rdValue,
  output logic       headEof,
  output logic       headCrc,
  output logic       dataEmpty,
  output logic       dataFull,
  output logic       qEmpty,
  output logic       qFull
);
  localparam int DW = 8 + 2;
  localparam int QW = CNT_W + 2;

  logic [DW-1:0] dataHead;
  logic [QW-1:0] qHead;
  logic [CNT_W-1:0] liveCnt, cntSel;
  logic overrun, qOvf, useQ;
  logic [1:0] statBits;

  fsq_ring #(.WIDTH(DW), .DEPTH(DATA_DEPTH)) u_dataRing (
    .clk(clk), .rstN(rstN),
    .push(strobes.dataPush), .pop(strobes.dataPop),
    .wrData({inEof, inCrcErr, inByte}), .rdData(dataHead),
    .empty(dataEmpty), .full(dataFull)
  );

  fsq_ring #(.WIDTH(QW), .DEPTH(QUEUE_DEPTH)) u_statRing (
    .clk(clk), .rstN(rstN),
    .push(strobes.qPush), .pop(strobes.qPop),
    .wrData({1'b1, inCrcErr, liveCnt + 1'b1}), .rdData(qHead),
    .empty(qEmpty), .full(qFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      overrun <= 1'b0;
      qOvf    <= 1'b0;
    end else begin
      if (inValid) liveCnt <= inEof ? '0 : liveCnt + 1'b1;
      if (inValid && dataFull) overrun <= 1'b1;
      else if (strobes.clrSticky) overrun <= 1'b0;
      if (strobes.qOvfSet) qOvf <= 1'b1;
      else if (strobes.clrSticky) qOvf <= 1'b0;
    end
  end

  assign headEof  = dataHead[DW-1];
  assign headCrc  = dataHead[DW-2];
  assign useQ     = cfgQueueEn && !qEmpty;
  assign cntSel   = useQ ? qHead[CNT_W-1:0] : liveCnt;
  assign statBits = useQ ? qHead[QW-1:QW-2]
                  : (dataEmpty ? 2'b00 : {headEof, headCrc});

  always_comb begin
    case (rdSel_t'(rdSel))
      SEL_DATA:   rdValue = dataEmpty ? 8'h00 : dataHead[7:0];
      SEL_CNT_LO: rdValue = cntSel[7:0];
      SEL_CNT_HI: rdValue = 8'(cntSel >> 8);
      default:    rdValue = {statBits, overrun, qOvf, 4'b0000};
    endcase
  end

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEof) |=> (liveCnt == '0)); // R2
  AST_QOVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (qOvf && !strobes.clrSticky) |=> qOvf); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !strobes.clrSticky) |=> overrun); // R1
endmodule

// File: rtl/fsq_control.sv
module fsq_control
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inEof,
  input  logic       cfgQueueEn,
  input  logic [1:0] cfgIrqMode,
  input  logic       cmdErrReset,
  input  logic       cmdResetIus,
  input  logic       rdStrobe,
  input  logic [1:0] rdSel,
  input  logic       headEof,
  input  logic       headCrc,
  input  logic       dataEmpty,
  input  logic       dataFull,
  input  logic       qEmpty,
  input  logic       qFull,
  output strobes_t   strobes,
  output logic       irq
);
  irqMode_t   mode;
  lockState_t lockState;
  logic statusRead, dataRead, exemptEof, headSpecial, headEofAvail, lockable;
  logic eofIrq, eofTaken, firstArmed, firstPend;

  assign mode         = irqMode_t'(cfgIrqMode);
  assign statusRead   = rdStrobe && (rdSel_t'(rdSel) == SEL_STATUS);
  assign dataRead     = rdStrobe && (rdSel_t'(rdSel) == SEL_DATA);
  assign exemptEof    = cfgQueueEn && (mode == IRQ_SPECIAL);
  assign headSpecial  = !dataEmpty && (headCrc || (headEof && !exemptEof));
  assign headEofAvail = !dataEmpty && headEof && !headCrc && exemptEof;
  assign lockable     = (mode == IRQ_FIRST) || (mode == IRQ_SPECIAL);

  always_comb begin
    strobes.dataPush  = inValid && !dataFull;
    strobes.dataPop   = dataRead && !dataEmpty && (lockState != LK_FROZEN);
    strobes.qPush     = inValid && inEof && cfgQueueEn && !qFull;
    strobes.qOvfSet   = inValid && inEof && cfgQueueEn && qFull;
    strobes.qPop      = statusRead && cfgQueueEn && !qEmpty;
    strobes.clrSticky = cmdErrReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_OPEN;
    end else if (cmdErrReset) begin
      lockState <= LK_OPEN;
    end else begin
      case (lockState)
        LK_OPEN:   if (statusRead && lockable && headSpecial) lockState <= LK_HELD;
        LK_HELD:   if (strobes.dataPop) lockState <= LK_FROZEN;
        default:   lockState <= LK_FROZEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eofIrq     <= 1'b0;
      eofTaken   <= 1'b0;
      firstArmed <= 1'b1;
      firstPend  <= 1'b0;
    end else begin
      if (strobes.dataPop) eofTaken <= 1'b0;
      else if (headEofAvail) eofTaken <= 1'b1;

      if (headEofAvail && !eofTaken && !strobes.dataPop) eofIrq <= 1'b1;
      else if (cmdResetIus) eofIrq <= 1'b0;

      if (cmdErrReset) firstArmed <= 1'b1;
      else if (strobes.dataPush && mode == IRQ_FIRST) firstArmed <= 1'b0;

      if (strobes.dataPush && firstArmed && mode == IRQ_FIRST) firstPend <= 1'b1;
      else if (cmdResetIus) firstPend <= 1'b0;
    end
  end

  assign irq = (mode != IRQ_OFF) &&
               ((headSpecial && lockState == LK_OPEN) || eofIrq ||
                (mode == IRQ_ALL && !dataEmpty) ||
                (mode == IRQ_FIRST && firstPend));

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_FROZEN && !cmdErrReset) |=> (lockState == LK_FROZEN)); // R6
  AST_ALL_NEVER_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_OPEN && mode == IRQ_ALL) |=> (lockState == LK_OPEN)); // R7
  AST_EOF_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (eofIrq && !cmdResetIus) |=> eofIrq); // R8
  AST_ERR_RESET_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    cmdErrReset |=> (lockState == LK_OPEN)); // R9
endmodule

// File: rtl/frame_status_ctrl.sv
module frame_status_ctrl
  import fsq_pkg::*;
#(
  parameter int DATA_DEPTH  = 8,
  parameter int QUEUE_DEPTH = 10,
  parameter int CNT_W       = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       inEof,
  input  logic       inCrcErr,
  input  logic       cfgQueueEn,
  input  logic [1:0] cfgIrqMode,
  input  logic       cmdErrReset,
  input  logic       cmdResetIus,
  input  logic       rdStrobe,
  input  logic [1:0] rdSel,
  output logic [7:0] rdValue,
  output logic       irq
);
  strobes_t strobes;
  logic headEof, headCrc, dataEmpty, dataFull, qEmpty, qFull;

  fsq_control u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof),
    .cfgQueueEn(cfgQueueEn), .cfgIrqMode(cfgIrqMode),
    .cmdErrReset(cmdErrReset), .cmdResetIus(cmdResetIus),
    .rdStrobe(rdStrobe), .rdSel(rdSel),
    .headEof(headEof), .headCrc(headCrc), .dataEmpty(dataEmpty),
    .dataFull(dataFull), .qEmpty(qEmpty), .qFull(qFull),
    .strobes(strobes), .irq(irq)
  );

  fsq_datapath #(
    .DATA_DEPTH(DATA_DEPTH), .QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inValid(inValid), .inByte(inByte), .inEof(inEof), .inCrcErr(inCrcErr),
    .cfgQueueEn(cfgQueueEn), .rdSel(rdSel), .rdValue(rdValue),
    .headEof(headEof), .headCrc(headCrc), .dataEmpty(dataEmpty),
    .dataFull(dataFull), .qEmpty(qEmpty), .qFull(qFull)
  );
endmodule

// File: tb/frame_status_ctrl_bench.sv
module frame_status_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inEof = 1'b0, inCrcErr = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic cfgQueueEn = 1'b0;
  logic [1:0] cfgIrqMode = 2'd0;
  logic cmdErrReset = 1'b0, cmdResetIus = 1'b0;
  logic rdStrobe = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic [7:0] rdValue;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct { int exp; string tag; } expItem_t;
  expItem_t expQ[$];
  event sampleEv;

  always #2 clk = ~clk;

  frame_status_ctrl u_frame_status_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inEof(inEof), .inCrcErr(inCrcErr), .cfgQueueEn(cfgQueueEn),
    .cfgIrqMode(cfgIrqMode), .cmdErrReset(cmdErrReset),
    .cmdResetIus(cmdResetIus), .rdStrobe(rdStrobe), .rdSel(rdSel),
    .rdValue(rdValue), .irq(irq)
  );

  function automatic void check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // monitor: pops the scoreboard when the driver marks a read as stable
  always @(sampleEv) begin
    expItem_t it;
    if (expQ.size() == 0) check("scoreboard underflow", 1, 0);
    else begin
      it = expQ.pop_front();
      check(it.tag, int'(rdValue), it.exp);
    end
  end

  task automatic hostRead(input logic [1:0] sel, input int exp, input string tag);
    expItem_t it;
    @(negedge clk);
    rdSel = sel;
    rdStrobe = 1'b1;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    #1 -> sampleEv;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic eof, input logic crc);
    @(negedge clk);
    inValid = 1'b1; inByte = b; inEof = eof; inCrcErr = crc;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0; inCrcErr = 1'b0;
  endtask

  task automatic pulseErr();
    @(negedge clk); cmdErrReset = 1'b1;
    @(negedge clk); cmdErrReset = 1'b0;
  endtask

  task automatic pulseIus();
    @(negedge clk); cmdResetIus = 1'b1;
    @(negedge clk); cmdResetIus = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset irq low", int'(irq), 0);
    hostRead(2'd3, 8'h00, "reset status R4");
    hostRead(2'd1, 8'h00, "reset count R2");

    // A: FIFO order, drop when full, live count (queue off, mode 0)
    for (int i = 0; i < 9; i++) sendByte(8'h10 + 8'(i), 1'b0, 1'b0);
    check("mode0 irq R12", int'(irq), 0);
    hostRead(2'd1, 9, "live count R2");
    hostRead(2'd3, 8'h20, "overrun bit R1");
    for (int i = 0; i < 8; i++) hostRead(2'd0, 8'h10 + i, "fifo order R1");
    pulseErr();
    hostRead(2'd3, 8'h00, "sticky cleared R9");
    sendByte(8'h19, 1'b1, 1'b0);
    hostRead(2'd0, 8'h19, "end byte R1");
    hostRead(2'd1, 8'h00, "count restart R2");

    // B: queue on, special only: end of frame gives data-available, no lock
    cfgQueueEn = 1'b1; cfgIrqMode = 2'd3;
    sendByte(8'hA1, 1'b0, 1'b0);
    sendByte(8'hA2, 1'b0, 1'b0);
    sendByte(8'hA3, 1'b1, 1'b0);
    sendByte(8'hB1, 1'b0, 1'b0);
    sendByte(8'hB2, 1'b1, 1'b0);
    check("no irq mid frame R5", int'(irq), 0);
    hostRead(2'd0, 8'hA1, "frame1 byte R5");
    hostRead(2'd0, 8'hA2, "frame1 byte R5");
    @(negedge clk);
    check("eof data-available irq R5", int'(irq), 1);
    hostRead(2'd1, 3, "frame1 count R2");
    hostRead(2'd2, 0, "frame1 count high R2");
    hostRead(2'd3, 8'h80, "frame1 status R4");
    hostRead(2'd0, 8'hA3, "frame1 end byte R5");
    @(negedge clk);
    check("irq held until reset-ius R8", int'(irq), 1);
    pulseIus();
    check("irq cleared by reset-ius R8", int'(irq), 0);
    hostRead(2'd0, 8'hB1, "next frame readable R5");
    @(negedge clk);
    check("second eof irq R5", int'(irq), 1);
    hostRead(2'd1, 2, "frame2 count R2");
    hostRead(2'd3, 8'h80, "frame2 status R4");
    hostRead(2'd0, 8'hB2, "frame2 end byte R5");
    pulseIus();
    check("irq clear after frame2 R8", int'(irq), 0);

    // C: queue overflow with 11 frames, mode 0
    cfgIrqMode = 2'd0;
    sendByte(8'h31, 1'b0, 1'b0);
    sendByte(8'h32, 1'b1, 1'b0);
    hostRead(2'd0, 8'h31, "frame byte R1");
    hostRead(2'd0, 8'h32, "frame byte R1");
    for (int f = 1; f < 11; f++) begin
      sendByte(8'h40 + 8'(f), 1'b1, (f == 1));
      hostRead(2'd0, 8'h40 + f, "frame byte R1");
    end
    hostRead(2'd1, 2, "queue head count R2");
    hostRead(2'd3, 8'h90, "queue overflow flag R3");
    hostRead(2'd3, 8'hD0, "crc frame status R4");
    for (int f = 2; f < 10; f++) hostRead(2'd3, 8'h90, "queued status R3");
    hostRead(2'd3, 8'h10, "eleventh frame dropped R3");
    pulseErr();
    hostRead(2'd3, 8'h00, "overflow cleared R9");

    // D: queue off, special only: end of frame locks
    cfgQueueEn = 1'b0; cfgIrqMode = 2'd3;
    sendByte(8'hC1, 1'b0, 1'b0);
    sendByte(8'hC2, 1'b1, 1'b0);
    sendByte(8'hD1, 1'b0, 1'b0);
    check("no special yet R10", int'(irq), 0);
    hostRead(2'd0, 8'hC1, "byte before eof R10");
    check("eof special irq R10", int'(irq), 1);
    hostRead(2'd3, 8'h80, "eof status at head R10");
    hostRead(2'd0, 8'hC2, "special byte removed R6");
    hostRead(2'd0, 8'hD1, "locked head R6");
    hostRead(2'd0, 8'hD1, "locked head repeats R6");
    check("irq masked while locked R6", int'(irq), 0);
    pulseErr();
    hostRead(2'd0, 8'hD1, "unlocked read R9");
    hostRead(2'd0, 8'h00, "fifo empty after unlock R9");

    // E: every-character mode never locks
    cfgIrqMode = 2'd2;
    sendByte(8'hE1, 1'b1, 1'b0);
    check("all-char irq R7", int'(irq), 1);
    hostRead(2'd3, 8'h80, "special in all mode R7");
    hostRead(2'd0, 8'hE1, "read special R7");
    check("irq low when empty R7", int'(irq), 0);
    sendByte(8'hE2, 1'b0, 1'b0);
    hostRead(2'd0, 8'hE2, "no lock in all mode R7");

    // F: first-character mode
    cfgIrqMode = 2'd1;
    sendByte(8'hF1, 1'b0, 1'b0);
    check("first char irq R11", int'(irq), 1);
    hostRead(2'd0, 8'hF1, "first char data R11");
    check("first irq held R11", int'(irq), 1);
    pulseIus();
    check("first irq cleared R11", int'(irq), 0);
    sendByte(8'hF2, 1'b0, 1'b0);
    check("no second first-char irq R11", int'(irq), 0);
    hostRead(2'd0, 8'hF2, "second char data R11");

    // G: mode 0 quiet even with crc error
    cfgIrqMode = 2'd0;
    sendByte(8'h77, 1'b1, 1'b1);
    check("mode0 quiet on crc R12", int'(irq), 0);
    hostRead(2'd0, 8'h77, "crc byte R12");

    @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    finish();
  end
endmodule